// File: doc/BRIEF.md
# String Operation Sequencer

This block runs one string primitive (block move, element compare, scan against the accumulator, load into the accumulator, or store from the accumulator) for a single element or in a counted loop. The source element sits at the source segment base plus the source pointer, and the destination element sits at the destination segment base plus the destination pointer. Each physical address is the segment shifted left by four bits plus the 16-bit offset, truncated to 20 bits. Between elements the pointers move by one byte or one word, upward or downward according to the direction input. When a repeat prefix is present, the count register is decremented once per element.

For compare and scan, the zero flag records whether the two values were equal. A while-equal loop stops at the first mismatch. A while-not-equal loop stops at the first match. Every loop also ends when the count reaches zero. A prefixed loop whose count starts at zero completes without touching memory.

The caller loads the operation, the operands and the starting register values, and pulses `start`. The block then issues single-element read and write requests on a simple request/ready memory port. When the sequence ends, it returns the updated pointers, count, accumulator and zero flag together with a one-cycle `done_o`.

Top module: `strop_seq`

## Requirements
- R1: The source address is (src_seg_i × 16 + SI) truncated to 20 bits, so a sum above 0xFFFFF wraps into the low megabyte.
- R2: The destination address is always (dst_seg_i × 16 + DI) truncated to 20 bits.
- R3: After each element, every pointer the operation uses is incremented when dir_i = 0 and decremented when dir_i = 1, wrapping modulo 2^16. Move, compare and load use SI. Move, compare, scan and store use DI.
- R4: The pointer step is 1 when wide_i = 0 (byte) and 2 when wide_i = 1 (word). mem_wide_o follows wide_i.
- R5: With a prefix (rep_i = 1 or 3 for while-equal, rep_i = 2 for while-not-equal), CX is decremented by one after each element. Move, load and store repeat until CX reaches zero; the prefix kind has no effect on them.
- R6: With a prefix and CX = 0 at the start, no memory request is made, SI, DI and CX keep their start values, and done_o follows.
- R7: With rep_i = 0, exactly one element is processed and CX is returned unchanged.
- R8: Compare (op_i = 1) reads the source element and then the destination element and sets ZF when source minus destination is zero. Scan (op_i = 2) compares the accumulator with the destination element in the same way. Neither compare nor scan writes memory.
- R9: A while-equal compare or scan stops after the first element with ZF = 0, or when CX reaches zero.
- R10: A while-not-equal compare or scan stops after the first element with ZF = 1, or when CX reaches zero.
- R11: A request (mem_req_o) keeps its address, write enable and data until mem_ready_i is sampled high, and only then does the sequencer advance.
- R12: Byte elements use the low 8 bits of the data bus. A byte load replaces only acc[7:0]. A byte store writes acc[7:0] zero-extended. A word load replaces the whole accumulator. Move is op_i = 0, load is op_i = 3, store is op_i = 4.
- R13: Reset clears all register outputs, busy_o, done_o and mem_req_o. busy_o is high from the accepted start until done_o, and done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| op_i | input | 3 | Operation: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| wide_i | input | 1 | 0 byte elements, 1 word elements |
| rep_i | input | 2 | 0 none, 1/3 while-equal, 2 while-not-equal |
| dir_i | input | 1 | 0 increment pointers, 1 decrement |
| src_seg_i | input | 16 | Source segment (data segment or its override) |
| dst_seg_i | input | 16 | Destination segment (extra segment) |
| si_i | input | 16 | Start source pointer |
| di_i | input | 16 | Start destination pointer |
| cx_i | input | 16 | Start count |
| acc_i | input | 16 | Start accumulator |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_wide_o | output | 1 | Request is a word access |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_ready_i | input | 1 | Request completes this cycle |
| si_o | output | 16 | Updated source pointer |
| di_o | output | 16 | Updated destination pointer |
| cx_o | output | 16 | Updated count |
| acc_o | output | 16 | Updated accumulator |
| zf_o | output | 1 | Zero flag from the last compare or scan |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the following on every cycle:
- a pending request holds its address and write enable until ready;
- compare, scan and load never write;
- each prefixed step lowers the count by exactly one;
- an unprefixed step leaves the count alone;
- a zero count under a prefix goes straight to completion;
- completion lasts one cycle.

Only the bench scenarios can show the rest: the actual addresses, including the 20-bit wrap; pointer movement in both directions for both element sizes; where a while-equal or while-not-equal loop stops; and the byte-lane treatment of loads and stores. The bench shows these by comparing final registers, access counts and the whole memory image against an independently computed expectation.

// File: rtl/strop_pkg.sv
package strop_pkg;

   typedef enum logic [2:0] {
      OP_MOVE  = 3'd0,
      OP_CMP   = 3'd1,
      OP_SCAN  = 3'd2,
      OP_LOAD  = 3'd3,
      OP_STORE = 3'd4
   } str_op_e;

   typedef enum logic [1:0] {
      RP_NONE   = 2'd0,
      RP_EQ     = 2'd1,
      RP_NE     = 2'd2,
      RP_EQ_ALT = 2'd3
   } rep_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_RD_SRC,
      S_RD_DST,
      S_WR_DST,
      S_STEP,
      S_FIN
   } seq_st_e;

   function automatic logic op_uses_src(input str_op_e op);
      return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
   endfunction

   function automatic logic op_uses_dst(input str_op_e op);
      return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_SCAN) || (op == OP_STORE);
   endfunction

   function automatic logic op_is_test(input str_op_e op);
      return (op == OP_CMP) || (op == OP_SCAN);
   endfunction

   function automatic logic rep_wants_eq(input rep_e r);
      return (r == RP_EQ) || (r == RP_EQ_ALT);
   endfunction

endpackage

// File: rtl/strop_addr.sv
module strop_addr #(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] phys
);
   localparam int BASE_W = SEG_W + SEG_SHIFT;

   logic [BASE_W-1:0] base;

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign base = seg;
      end else begin : g_shifted
         assign base = {seg, {SEG_SHIFT{1'b0}}};
      end
   endgenerate

   assign phys = ADDR_W'(base) + ADDR_W'(off);

   initial begin
      AST_ADDR_FITS: assert (ADDR_W <= BASE_W + 1 && ADDR_W >= OFF_W)
         else $error("strop_addr: ADDR_W out of range");
   end
endmodule

// File: rtl/strop_step.sv
module strop_step #(
   parameter int OFF_W     = 16,
   parameter int WIDE_STEP = 2
) (
   input  logic [OFF_W-1:0] ptr,
   input  logic             dir,
   input  logic             wide,
   output logic [OFF_W-1:0] ptr_next
);
   logic [OFF_W-1:0] amount;

   assign amount   = wide ? OFF_W'(WIDE_STEP) : OFF_W'(1);
   assign ptr_next = dir ? (ptr - amount) : (ptr + amount);

   initial begin
      AST_STEP_RANGE: assert (WIDE_STEP >= 2 && WIDE_STEP < (1 << (OFF_W - 1)))
         else $error("strop_step: WIDE_STEP out of range");
   end
endmodule

// File: rtl/strop_cmp.sv
module strop_cmp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              wide,
   output logic              equal
);
   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] lane_eq;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         assign lane_eq[g] = (lhs[g*8 +: 8] == rhs[g*8 +: 8]);
      end
   endgenerate

   assign equal = wide ? (&lane_eq) : lane_eq[0];

   initial begin
      AST_CMP_LANES: assert (DATA_W % 8 == 0 && LANES >= 2)
         else $error("strop_cmp: DATA_W must be a multiple of 8, at least 16");
   end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
   import strop_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_i,
   input  logic              wide_i,
   input  logic [1:0]        rep_i,
   input  logic              dir_i,
   input  logic [SEG_W-1:0]  src_seg_i,
   input  logic [SEG_W-1:0]  dst_seg_i,
   input  logic [OFF_W-1:0]  si_i,
   input  logic [OFF_W-1:0]  di_i,
   input  logic [CNT_W-1:0]  cx_i,
   input  logic [DATA_W-1:0] acc_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_wide_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic [OFF_W-1:0]  si_o,
   output logic [OFF_W-1:0]  di_o,
   output logic [CNT_W-1:0]  cx_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              zf_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int WIDE_STEP = DATA_W / 8;
   localparam int HI_W      = DATA_W - 8;

   seq_st_e             st_q, st_d;
   str_op_e             op_q;
   rep_e                rep_q;
   logic                wide_q, dir_q, zf_q;
   logic [SEG_W-1:0]    sseg_q, dseg_q;
   logic [OFF_W-1:0]    si_q, di_q;
   logic [CNT_W-1:0]    cx_q;
   logic [DATA_W-1:0]   acc_q, tmp_q;

   logic [ADDR_W-1:0]   src_addr, dst_addr;
   logic [OFF_W-1:0]    ptr_cur [2];
   logic [OFF_W-1:0]    ptr_nxt [2];
   logic [DATA_W-1:0]   rd_elem, cmp_lhs, acc_loaded;
   logic                elem_eq;
   logic [CNT_W-1:0]    cx_dec;
   logic                is_last;

   // ---------------- address generation ----------------
   strop_addr #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) u_src_addr (
      .seg(sseg_q), .off(si_q), .phys(src_addr)
   );

   strop_addr #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) u_dst_addr (
      .seg(dseg_q), .off(di_q), .phys(dst_addr)
   );

   // ---------------- pointer steppers (0 = source, 1 = destination) ----------------
   assign ptr_cur[0] = si_q;
   assign ptr_cur[1] = di_q;

   genvar p;
   generate
      for (p = 0; p < 2; p++) begin : g_ptr
         strop_step #(
            .OFF_W(OFF_W), .WIDE_STEP(WIDE_STEP)
         ) u_step (
            .ptr(ptr_cur[p]), .dir(dir_q), .wide(wide_q), .ptr_next(ptr_nxt[p])
         );
      end
   endgenerate

   // ---------------- element data ----------------
   assign rd_elem    = wide_q ? mem_rdata_i : {{HI_W{1'b0}}, mem_rdata_i[7:0]};
   assign acc_loaded = wide_q ? mem_rdata_i : {acc_q[DATA_W-1:8], mem_rdata_i[7:0]};
   assign cmp_lhs    = (op_q == OP_CMP) ? tmp_q : acc_q;

   strop_cmp #(.DATA_W(DATA_W)) u_cmp (
      .lhs(cmp_lhs), .rhs(mem_rdata_i), .wide(wide_q), .equal(elem_eq)
   );

   // ---------------- loop exit decision ----------------
   assign cx_dec  = cx_q - CNT_W'(1);
   always_comb begin
      is_last = 1'b0;
      if (rep_q == RP_NONE) begin
         is_last = 1'b1;
      end else if (cx_dec == '0) begin
         is_last = 1'b1;
      end else if (op_is_test(op_q)) begin
         if (rep_wants_eq(rep_q) && !zf_q) is_last = 1'b1;
         if ((rep_q == RP_NE) && zf_q)     is_last = 1'b1;
      end
   end

   // ---------------- next state ----------------
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:   if (start) st_d = S_CHECK;
         S_CHECK: begin
            if ((rep_q != RP_NONE) && (cx_q == '0)) begin
               st_d = S_FIN;
            end else begin
               case (op_q)
                  OP_MOVE, OP_CMP, OP_LOAD: st_d = S_RD_SRC;
                  OP_SCAN:                  st_d = S_RD_DST;
                  OP_STORE:                 st_d = S_WR_DST;
                  default:                  st_d = S_FIN;
               endcase
            end
         end
         S_RD_SRC: begin
            if (mem_ready_i) begin
               case (op_q)
                  OP_MOVE: st_d = S_WR_DST;
                  OP_CMP:  st_d = S_RD_DST;
                  default: st_d = S_STEP;
               endcase
            end
         end
         S_RD_DST: if (mem_ready_i) st_d = S_STEP;
         S_WR_DST: if (mem_ready_i) st_d = S_STEP;
         S_STEP:   st_d = is_last ? S_FIN : S_CHECK;
         S_FIN:    st_d = S_IDLE;
         default:  st_d = S_IDLE;
      endcase
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         op_q   <= OP_MOVE;
         rep_q  <= RP_NONE;
         wide_q <= 1'b0;
         dir_q  <= 1'b0;
         zf_q   <= 1'b0;
         sseg_q <= '0;
         dseg_q <= '0;
         si_q   <= '0;
         di_q   <= '0;
         cx_q   <= '0;
         acc_q  <= '0;
         tmp_q  <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  op_q   <= str_op_e'(op_i);
                  rep_q  <= rep_e'(rep_i);
                  wide_q <= wide_i;
                  dir_q  <= dir_i;
                  sseg_q <= src_seg_i;
                  dseg_q <= dst_seg_i;
                  si_q   <= si_i;
                  di_q   <= di_i;
                  cx_q   <= cx_i;
                  acc_q  <= acc_i;
               end
            end
            S_RD_SRC: begin
               if (mem_ready_i) begin
                  tmp_q <= rd_elem;
                  if (op_q == OP_LOAD) acc_q <= acc_loaded;
               end
            end
            S_RD_DST: begin
               if (mem_ready_i) zf_q <= elem_eq;
            end
            S_STEP: begin
               if (op_uses_src(op_q)) si_q <= ptr_nxt[0];
               if (op_uses_dst(op_q)) di_q <= ptr_nxt[1];
               if (rep_q != RP_NONE)  cx_q <= cx_dec;
            end
            default: ;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign mem_req_o   = (st_q == S_RD_SRC) || (st_q == S_RD_DST) || (st_q == S_WR_DST);
   assign mem_we_o    = (st_q == S_WR_DST);
   assign mem_wide_o  = wide_q;
   assign mem_addr_o  = (st_q == S_RD_SRC) ? src_addr : dst_addr;
   always_comb begin
      if (op_q == OP_STORE)
         mem_wdata_o = wide_q ? acc_q : {{HI_W{1'b0}}, acc_q[7:0]};
      else
         mem_wdata_o = tmp_q;
   end

   assign si_o   = si_q;
   assign di_o   = di_q;
   assign cx_o   = cx_q;
   assign acc_o  = acc_q;
   assign zf_o   = zf_q;
   assign busy_o = (st_q != S_IDLE);
   assign done_o = (st_q == S_FIN);

   // ---------------- assertions ----------------
   initial begin
      AST_PARAM_WIDTHS: assert (DATA_W >= 16 && CNT_W >= 1 && OFF_W >= 2)
         else $error("strop_seq: bad width parameters");
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R11

   AST_NO_WRITE_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (op_q == OP_CMP || op_q == OP_SCAN || op_q == OP_LOAD)) |-> !mem_we_o); // R8

   AST_CX_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_STEP && rep_q != RP_NONE) |=> (cx_o == $past(cx_o) - CNT_W'(1))); // R5

   AST_CX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_STEP && rep_q == RP_NONE) |=> $stable(cx_o)); // R7

   AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CHECK && rep_q != RP_NONE && cx_q == '0) |=> (done_o && !mem_req_o)); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R13
endmodule

// File: tb/strop_seq_tb.sv
`timescale 1ns/1ps
module strop_seq_tb;

   typedef struct packed {
      logic [2:0]  op;
      logic        wide;
      logic [1:0]  rep;
      logic        dir;
      logic [15:0] sseg;
      logic [15:0] dseg;
      logic [15:0] si;
      logic [15:0] di;
      logic [15:0] cx;
      logic [15:0] acc;
      logic [1:0]  waitn;
      logic        poke;
      logic [9:0]  paddr;
      logic [7:0]  pval;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 13;
   // op: 0 move, 1 cmp, 2 scan, 3 load, 4 store; rep: 0 none, 1 eq, 2 ne
   localparam vec_t VECS [NV] = '{
      '{3'd0,1'b1,2'd0,1'b0,16'h0010,16'h0020,16'h0004,16'h0010,16'd5, 16'h0000,2'd0,1'b0,10'h000,8'h00,4'd7},  // R7 R4 single word move
      '{3'd0,1'b0,2'd1,1'b0,16'h0010,16'h0020,16'h0000,16'h0040,16'd6, 16'h0000,2'd1,1'b0,10'h000,8'h00,4'd5},  // R5 byte move loop
      '{3'd0,1'b1,2'd2,1'b1,16'h0010,16'h0020,16'h0020,16'h0080,16'd4, 16'h0000,2'd2,1'b0,10'h000,8'h00,4'd3},  // R3 word move downward
      '{3'd1,1'b0,2'd1,1'b0,16'h0010,16'h0020,16'h0010,16'h0010,16'd8, 16'h0000,2'd0,1'b1,10'h213,8'h55,4'd9},  // R9 mismatch stop
      '{3'd1,1'b1,2'd1,1'b0,16'h0010,16'h0020,16'h0030,16'h0030,16'd3, 16'h0000,2'd1,1'b0,10'h000,8'h00,4'd9},  // R9 count runs out
      '{3'd2,1'b0,2'd2,1'b0,16'h0010,16'h0020,16'h0000,16'h0000,16'd20,16'h0007,2'd1,1'b0,10'h000,8'h00,4'd10}, // R10 match stop
      '{3'd2,1'b1,2'd2,1'b0,16'h0010,16'h0020,16'h0000,16'h0060,16'd4, 16'hFFFF,2'd0,1'b0,10'h000,8'h00,4'd10}, // R10 no match
      '{3'd3,1'b0,2'd1,1'b1,16'h0010,16'h0020,16'h0008,16'h0000,16'd3, 16'hAB00,2'd0,1'b0,10'h000,8'h00,4'd12}, // R12 byte load
      '{3'd4,1'b1,2'd1,1'b0,16'h0010,16'h0020,16'h0000,16'h0100,16'd3, 16'h1234,2'd2,1'b0,10'h000,8'h00,4'd2},  // R2 word store
      '{3'd4,1'b0,2'd0,1'b0,16'h0010,16'h0020,16'h0000,16'h0005,16'd7, 16'h12C3,2'd0,1'b0,10'h000,8'h00,4'd12}, // R12 byte store
      '{3'd0,1'b1,2'd1,1'b0,16'h0010,16'h0020,16'h0002,16'h0004,16'd0, 16'h0000,2'd0,1'b0,10'h000,8'h00,4'd6},  // R6 zero count
      '{3'd1,1'b1,2'd0,1'b0,16'h0010,16'h0020,16'h0002,16'h0004,16'd9, 16'h0000,2'd1,1'b0,10'h000,8'h00,4'd8},  // R8 single compare
      '{3'd0,1'b0,2'd0,1'b0,16'hFFFF,16'h0020,16'hFFFF,16'h01F0,16'd1, 16'h0000,2'd0,1'b0,10'h000,8'h00,4'd1}   // R1 address wrap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_i = '0;
   logic        wide_i = 1'b0;
   logic [1:0]  rep_i = '0;
   logic        dir_i = 1'b0;
   logic [15:0] src_seg_i = '0, dst_seg_i = '0, si_i = '0, di_i = '0, cx_i = '0, acc_i = '0;
   logic        mem_req, mem_we, mem_wide;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic [15:0] si_o, di_o, cx_o, acc_o;
   logic        zf_o, busy_o, done_o;

   always #2.5 clk = ~clk;

   strop_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .wide_i(wide_i),
      .rep_i(rep_i), .dir_i(dir_i), .src_seg_i(src_seg_i), .dst_seg_i(dst_seg_i),
      .si_i(si_i), .di_i(di_i), .cx_i(cx_i), .acc_i(acc_i),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .mem_ready_i(mem_ready), .si_o(si_o), .di_o(di_o), .cx_o(cx_o),
      .acc_o(acc_o), .zf_o(zf_o), .busy_o(busy_o), .done_o(done_o)
   );

   logic [7:0] mem     [1024];
   logic [7:0] ref_mem [1024];
   int  n_checks = 0, n_fail = 0;
   int  rd_cnt = 0, wr_cnt = 0;
   int  wait_cfg = 0;
   int  cycles = 0;
   bit  finished = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // memory responder: acknowledges after wait_cfg idle cycles
   initial begin
      int wc = 0;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
            wc = 0;
         end else if (mem_req) begin
            if (wc >= wait_cfg) begin
               logic [9:0] a0, a1;
               a0 = mem_addr[9:0];
               a1 = a0 + 10'd1;
               if (mem_we) begin
                  mem[a0] = mem_wdata[7:0];
                  if (mem_wide) mem[a1] = mem_wdata[15:8];
                  wr_cnt++;
               end else begin
                  mem_rdata = mem_wide ? {mem[a1], mem[a0]} : {8'h00, mem[a0]};
                  rd_cnt++;
               end
               mem_ready = 1'b1;
            end else begin
               wc++;
            end
         end
      end
   end

   function automatic logic [15:0] ref_rd(input logic [19:0] a, input logic w);
      logic [9:0] i0 = a[9:0];
      logic [9:0] i1 = i0 + 10'd1;
      return w ? {ref_mem[i1], ref_mem[i0]} : {8'h00, ref_mem[i0]};
   endfunction

   // independent expectation from the requirement list
   task automatic run_ref(input vec_t v, output logic [15:0] esi, output logic [15:0] edi,
                          output logic [15:0] ecx, output logic [15:0] eacc,
                          output logic ezf, output int erd, output int ewr);
      logic [15:0] s = v.si, d = v.di, c = v.cx, ac = v.acc, sv, dv, stp;
      logic z = 1'b0;
      logic stop = 1'b0;
      erd = 0; ewr = 0;
      stp = v.wide ? 16'd2 : 16'd1;
      if (v.rep != 2'd0 && c == 16'd0) stop = 1'b1;
      for (int guard = 0; guard < 70000 && !stop; guard++) begin
         logic [19:0] sa = {v.sseg, 4'h0} + {4'h0, s};
         logic [19:0] da = {v.dseg, 4'h0} + {4'h0, d};
         sv = 16'h0;
         if (v.op == 3'd0 || v.op == 3'd1 || v.op == 3'd3) begin
            sv = ref_rd(sa, v.wide); erd++;
         end
         if (v.op == 3'd1 || v.op == 3'd2) begin
            dv = ref_rd(da, v.wide); erd++;
            z = (v.op == 3'd1) ? (sv == dv)
                               : (v.wide ? (ac == dv) : (ac[7:0] == dv[7:0]));
         end
         if (v.op == 3'd3) ac = v.wide ? sv : {ac[15:8], sv[7:0]};
         if (v.op == 3'd0 || v.op == 3'd4) begin
            logic [15:0] wv = (v.op == 3'd4) ? (v.wide ? ac : {8'h00, ac[7:0]}) : sv;
            ref_mem[da[9:0]] = wv[7:0];
            if (v.wide) ref_mem[da[9:0] + 10'd1] = wv[15:8];
            ewr++;
         end
         if (v.op == 3'd0 || v.op == 3'd1 || v.op == 3'd3) s = v.dir ? s - stp : s + stp;
         if (v.op != 3'd3) d = v.dir ? d - stp : d + stp;
         if (v.rep == 2'd0) stop = 1'b1;
         else begin
            c = c - 16'd1;
            if (c == 16'd0) stop = 1'b1;
            if (v.op == 3'd1 || v.op == 3'd2) begin
               if ((v.rep == 2'd1 || v.rep == 2'd3) && !z) stop = 1'b1;
               if (v.rep == 2'd2 && z) stop = 1'b1;
            end
         end
      end
      esi = s; edi = d; ecx = c; eacc = ac; ezf = z;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input int k, input vec_t v);
      logic [15:0] esi, edi, ecx, eacc;
      logic ezf;
      int erd, ewr, t;
      bit mem_ok = 1;
      do_reset();
      for (int i = 0; i < 1024; i++) begin
         mem[i] = i[7:0];
         ref_mem[i] = i[7:0];
      end
      if (v.poke) begin
         mem[v.paddr] = v.pval;
         ref_mem[v.paddr] = v.pval;
      end
      run_ref(v, esi, edi, ecx, eacc, ezf, erd, ewr);
      wait_cfg = v.waitn;
      rd_cnt = 0; wr_cnt = 0;
      op_i = v.op; wide_i = v.wide; rep_i = v.rep; dir_i = v.dir;
      src_seg_i = v.sseg; dst_seg_i = v.dseg;
      si_i = v.si; di_i = v.di; cx_i = v.cx; acc_i = v.acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done_o && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(done_o, $sformatf("R13 vec%0d done seen", k), done_o, 1);
      chk(si_o == esi, $sformatf("R%0d vec%0d SI", v.rq, k), si_o, esi);
      chk(di_o == edi, $sformatf("R%0d vec%0d DI", v.rq, k), di_o, edi);
      chk(cx_o == ecx, $sformatf("R%0d vec%0d CX", v.rq, k), cx_o, ecx);
      chk(acc_o == eacc, $sformatf("R%0d vec%0d ACC", v.rq, k), acc_o, eacc);
      chk(zf_o == ezf, $sformatf("R%0d vec%0d ZF", v.rq, k), zf_o, ezf);
      chk(rd_cnt == erd, $sformatf("R%0d vec%0d reads", v.rq, k), rd_cnt, erd);
      chk(wr_cnt == ewr, $sformatf("R%0d vec%0d writes", v.rq, k), wr_cnt, ewr);
      for (int i = 0; i < 1024; i++) begin
         if (mem[i] !== ref_mem[i] && mem_ok) begin
            mem_ok = 0;
            chk(0, $sformatf("R%0d vec%0d memory at %0h", v.rq, k, i), mem[i], ref_mem[i]);
         end
      end
      if (mem_ok) chk(1, "memory image", 0, 0);
      @(negedge clk);
      chk(!done_o && !busy_o, $sformatf("R13 vec%0d done is one cycle", k), done_o, 0);
   endtask

   // watchdog
   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      // R13 reset state
      do_reset();
      chk(!busy_o && !done_o && !mem_req, "R13 reset control outputs", {busy_o, done_o, mem_req}, 0);
      chk(si_o == 0 && di_o == 0 && cx_o == 0 && acc_o == 0 && !zf_o,
          "R13 reset registers", si_o | di_o | cx_o | acc_o, 0);

      for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

      // R6: zero-count skip also for a compare; no request ever raised
      begin
         int saw_req = 0;
         do_reset();
         op_i = 3'd1; wide_i = 1'b0; rep_i = 2'd2; dir_i = 1'b1;
         si_i = 16'h1111; di_i = 16'h2222; cx_i = 16'd0; acc_i = 16'h0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         for (int c = 0; c < 6; c++) begin
            if (mem_req) saw_req++;
            @(negedge clk);
         end
         chk(saw_req == 0, "R6 zero count issues no request", saw_req, 0);
         chk(si_o == 16'h1111 && di_o == 16'h2222, "R6 pointers kept", si_o, 16'h1111);
      end

      // R11: request held while ready is withheld
      begin
         logic [19:0] a0;
         bit held = 1;
         do_reset();
         wait_cfg = 3;
         op_i = 3'd4; wide_i = 1'b1; rep_i = 2'd0; dir_i = 1'b0;
         dst_seg_i = 16'h0020; di_i = 16'h0008; acc_i = 16'hBEEF; cx_i = 16'd1;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         a0 = mem_addr;
         for (int c = 0; c < 3; c++) begin
            if (!mem_req || mem_addr != a0 || !mem_we) held = 0;
            @(negedge clk);
         end
         chk(held, "R11 request held until ready", mem_addr, a0);
         chk(a0 == 20'h00208, "R2 store address", a0, 20'h00208);
         repeat (4) @(negedge clk);
         chk({mem[10'h209], mem[10'h208]} == 16'hBEEF, "R11 data written after ready",
             {mem[10'h209], mem[10'h208]}, 16'hBEEF);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule